// File: doc/BRIEF.md
# Successive-Integration Conversion Sequencer

This block is the digital controller behind an integrating analog-to-digital converter. It drives the analog switch controls through a fixed series of phases. A plain dual-slope measurement is refined by two further de-integrate phases. Each of these measures the amplified residue that the previous phase left, and each adds one decade of resolution. A six-decade BCD up/down counter accumulates the reading. The up steps land on the hundreds decade in the first de-integrate phase. The down steps land on the tens decade in the second, and the up steps on the units decade in the third.

Each conversion runs two passes. The signal pass integrates the real input. The offset pass repeats the whole series with the inputs shorted internally. The offset reading, with its own polarity, is subtracted from the signal reading in BCD. A latch window then publishes the signed 4-1/2-digit result, an overload flag and a done strobe. The integrator and the comparator sit outside the block. The comparator reports whether the integrator has yet to cross zero, and a range select picks the long or the short integrate time.

The phases, by state name, are: PH_ZI (zero-integrate), PH_INT (integrate), PH_DE1, PH_RST1, PH_X1, PH_DE2, PH_RST2, PH_X2, PH_DE3 and PH_LATCH. The transitions run ZI→INT→DE1→RST1→X1→DE2→RST2→X2→DE3. In the signal pass DE3 then leads to ZI and the offset pass. In the offset pass DE3 leads to LATCH, and LATCH leads back to ZI.

Top module: `scs_conv_seq`

## Requirements
- R1: After reset the block is in zero-integrate of the signal pass: only `sw_zi_o` is high, `done_o` is low, and the result outputs are zero (magnitude 0, positive, no overload).
- R2: Phases follow the order ZI, INT, DE1, REST, X10, DE2, REST, X10, DE3. This is done once for the signal pass and once for the offset pass, and a latch window follows. A REST phase is always followed directly by an X10 phase.
- R3: The integrate phase lasts INT_LO_CLK clocks when `range_hi_i` is low, and INT_HI_CLK clocks when it is high. The range is sampled on the clock that enters integrate. `sw_int1_o` is used in the signal pass and `sw_int2_o` in the offset pass.
- R4: Zero-integrate lasts ZI_CLK clocks, each REST lasts REST_CLK clocks, each X10 lasts X10_CLK clocks, and the latch window lasts LATCH_CLK clocks.
- R5: A de-integrate phase ends on the first clock on which `cmp_i` is sampled low, and that clock takes no count step. With n clocks of `cmp_i` high it therefore lasts n+1 clocks.
- R6: During de-integrate, `sw_de_pos_o` is on when `in_neg_i` was low on the last integrate clock of the pass, and `sw_de_neg_o` is on otherwise.
- R7: A pass reading equals 100·n1 − 10·n2 + n3, where nk is the number of counted clocks in DEk (DE1 counts up in hundreds, DE2 counts down in tens, DE3 counts up in units).
- R8: The published result equals the signed signal reading minus the signed offset reading. It is given as BCD magnitude (`res_mag_o`, digit k in bits 4k+3..4k, units at bit 0) plus a sign (`res_neg_o` high for negative). A zero result is always positive.
- R9: A de-integrate phase with `cmp_i` still high after DE_MAX counted clocks ends after that last counted clock, and the conversion reports overload.
- R10: `res_ovr_o` is high when the corrected magnitude exceeds 19999.
- R11: `done_o` is high for exactly the latch window. The result outputs update only at the end of the first window clock and stay unchanged otherwise.
- R12: Exactly one of the seven switch controls and `done_o` is high in every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator: high while the integrator has not yet crossed zero |
| range_hi_i | input | 1 | High selects the short integrate time |
| in_neg_i | input | 1 | Input polarity, high for negative |
| sw_zi_o | output | 1 | Zero-integrate switch |
| sw_int1_o | output | 1 | Signal integrate switch |
| sw_int2_o | output | 1 | Offset (shorted input) integrate switch |
| sw_de_pos_o | output | 1 | De-integrate switch for positive input |
| sw_de_neg_o | output | 1 | De-integrate switch for negative input |
| sw_rest_o | output | 1 | Rest switch |
| sw_x10_o | output | 1 | Residue x10 amplification switch |
| done_o | output | 1 | High during the latch window |
| res_mag_o | output | 20 | Corrected magnitude, five BCD digits |
| res_neg_o | output | 1 | Sign of the corrected result |
| res_ovr_o | output | 1 | Over-range or de-integrate timeout |

## Verification
The bench builds the block with integrate lengths of 40 and 8 clocks and phase lengths of 4, 3, 2 and 5 clocks. It sets DE_MAX to 250, so the timeout is reached with 300 comparator-high clocks and a reading over 19999 with 210. With these values every conversion stays within a few hundred clocks. Both ranges, both polarities, zero-length de-integrate phases, an offset larger than the signal, offsets of either sign and an exactly cancelling offset all fit into seven conversions.

// File: rtl/scs_pkg.sv
package scs_pkg;

    localparam int NDIG = 6;
    localparam int DECW = $clog2(NDIG);

    typedef logic [4*NDIG-1:0] bcd_t;

    typedef enum logic [3:0] {
        PH_ZI, PH_INT, PH_DE1, PH_RST1, PH_X1,
        PH_DE2, PH_RST2, PH_X2, PH_DE3, PH_LATCH
    } phase_e;

    function automatic bcd_t bcd_add(input bcd_t a, input bcd_t b);
        bcd_t r;
        int   c;
        int   s;
        r = '0;
        c = 0;
        for (int i = 0; i < NDIG; i++) begin
            s = int'(a[4*i +: 4]) + int'(b[4*i +: 4]) + c;
            if (s > 9) begin
                s = s - 10;
                c = 1;
            end else begin
                c = 0;
            end
            r[4*i +: 4] = 4'(s);
        end
        return r;
    endfunction

    function automatic bcd_t bcd_sub(input bcd_t a, input bcd_t b);
        bcd_t r;
        int   c;
        int   s;
        r = '0;
        c = 0;
        for (int i = 0; i < NDIG; i++) begin
            s = int'(a[4*i +: 4]) - int'(b[4*i +: 4]) - c;
            if (s < 0) begin
                s = s + 10;
                c = 1;
            end else begin
                c = 0;
            end
            r[4*i +: 4] = 4'(s);
        end
        return r;
    endfunction

    function automatic logic bcd_less(input bcd_t a, input bcd_t b);
        int c;
        int s;
        c = 0;
        for (int i = 0; i < NDIG; i++) begin
            s = int'(a[4*i +: 4]) - int'(b[4*i +: 4]) - c;
            c = (s < 0) ? 1 : 0;
        end
        return (c != 0);
    endfunction

endpackage

// File: rtl/scs_phase_timer.sv
module scs_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       value <= '0;
        else if (restart) value <= '0;
        else              value <= value + 1'b1;
    end
endmodule

// File: rtl/scs_bcd_counter.sv
module scs_bcd_counter
    import scs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            step,
    input  logic            up,
    input  logic [DECW-1:0] dec,
    output bcd_t            value
);
    bcd_t stepv;
    bcd_t nxt;

    // one unit placed on the selected decade
    for (genvar g = 0; g < NDIG; g++) begin : g_dec
        assign stepv[4*g +: 4] = (dec == DECW'(g)) ? 4'd1 : 4'd0;
    end

    always_comb begin
        nxt = up ? bcd_add(value, stepv) : bcd_sub(value, stepv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     value <= '0;
        else if (clr)   value <= '0;
        else if (step)  value <= nxt;
    end
endmodule

// File: rtl/scs_correct.sv
module scs_correct
    import scs_pkg::*;
(
    input  bcd_t sig_mag,
    input  logic sig_neg,
    input  bcd_t off_mag,
    input  logic off_neg,
    output bcd_t out_mag,
    output logic out_neg
);
    bcd_t d_so;
    bcd_t d_os;
    bcd_t s_sum;
    logic so_less;

    always_comb begin
        d_so    = bcd_sub(sig_mag, off_mag);
        d_os    = bcd_sub(off_mag, sig_mag);
        s_sum   = bcd_add(sig_mag, off_mag);
        so_less = bcd_less(sig_mag, off_mag);
        if (sig_neg == off_neg) begin
            // same sign: magnitudes subtract
            out_mag = so_less ? d_os : d_so;
            out_neg = so_less ? !sig_neg : sig_neg;
        end else begin
            // opposite sign: magnitudes add
            out_mag = s_sum;
            out_neg = sig_neg;
        end
        if (out_mag == '0) out_neg = 1'b0;
    end
endmodule

// File: rtl/scs_conv_seq.sv
module scs_conv_seq
    import scs_pkg::*;
#(
    parameter int INT_LO_CLK = 10000,
    parameter int INT_HI_CLK = 1000,
    parameter int ZI_CLK     = 100,
    parameter int REST_CLK   = 100,
    parameter int X10_CLK    = 100,
    parameter int LATCH_CLK  = 100,
    parameter int DE_MAX     = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmp_i,
    input  logic        range_hi_i,
    input  logic        in_neg_i,
    output logic        sw_zi_o,
    output logic        sw_int1_o,
    output logic        sw_int2_o,
    output logic        sw_de_pos_o,
    output logic        sw_de_neg_o,
    output logic        sw_rest_o,
    output logic        sw_x10_o,
    output logic        done_o,
    output logic [19:0] res_mag_o,
    output logic        res_neg_o,
    output logic        res_ovr_o
);
    localparam int TA    = (INT_LO_CLK > INT_HI_CLK) ? INT_LO_CLK : INT_HI_CLK;
    localparam int TB    = (ZI_CLK > REST_CLK) ? ZI_CLK : REST_CLK;
    localparam int TC    = (X10_CLK > LATCH_CLK) ? X10_CLK : LATCH_CLK;
    localparam int TD    = (TA > TB) ? TA : TB;
    localparam int TE    = (TC > DE_MAX) ? TC : DE_MAX;
    localparam int T_MAX = (TD > TE) ? TD : TE;
    localparam int TW    = $clog2(T_MAX + 1);

    phase_e          state, nxt;
    logic            pass;
    logic            rng;
    logic            pol;
    logic [TW-1:0]   tmr;
    logic [TW-1:0]   int_last;
    logic            is_de, de_last, de_exit, de_tmo;
    logic            cnt_clr, cnt_step, cnt_up;
    logic [DECW-1:0] dec;
    bcd_t            cnt, sig_cnt, corr_mag;
    logic            sig_neg, corr_neg, ovl_acc;

    assign is_de    = (state == PH_DE1) || (state == PH_DE2) || (state == PH_DE3);
    assign de_last  = (tmr == TW'(DE_MAX - 1));
    assign de_exit  = is_de && (!cmp_i || de_last);
    assign de_tmo   = is_de && cmp_i && de_last;
    assign int_last = rng ? TW'(INT_HI_CLK - 1) : TW'(INT_LO_CLK - 1);

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            PH_ZI:    if (tmr == TW'(ZI_CLK - 1))    nxt = PH_INT;
            PH_INT:   if (tmr == int_last)           nxt = PH_DE1;
            PH_DE1:   if (de_exit)                   nxt = PH_RST1;
            PH_RST1:  if (tmr == TW'(REST_CLK - 1))  nxt = PH_X1;
            PH_X1:    if (tmr == TW'(X10_CLK - 1))   nxt = PH_DE2;
            PH_DE2:   if (de_exit)                   nxt = PH_RST2;
            PH_RST2:  if (tmr == TW'(REST_CLK - 1))  nxt = PH_X2;
            PH_X2:    if (tmr == TW'(X10_CLK - 1))   nxt = PH_DE3;
            PH_DE3:   if (de_exit)                   nxt = pass ? PH_LATCH : PH_ZI;
            PH_LATCH: if (tmr == TW'(LATCH_CLK - 1)) nxt = PH_ZI;
            default:                                 nxt = PH_ZI;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_ZI;
            pass  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == PH_DE3 && de_exit && !pass)     pass <= 1'b1;
            else if (state == PH_LATCH && nxt == PH_ZI)  pass <= 1'b0;
        end
    end

    // switch and strobe outputs
    always_comb begin
        sw_zi_o     = 1'b0;
        sw_int1_o   = 1'b0;
        sw_int2_o   = 1'b0;
        sw_de_pos_o = 1'b0;
        sw_de_neg_o = 1'b0;
        sw_rest_o   = 1'b0;
        sw_x10_o    = 1'b0;
        done_o      = 1'b0;
        unique case (state)
            PH_ZI:                   sw_zi_o = 1'b1;
            PH_INT:                  if (pass) sw_int2_o = 1'b1; else sw_int1_o = 1'b1;
            PH_DE1, PH_DE2, PH_DE3:  if (pol) sw_de_neg_o = 1'b1; else sw_de_pos_o = 1'b1;
            PH_RST1, PH_RST2:        sw_rest_o = 1'b1;
            PH_X1, PH_X2:            sw_x10_o = 1'b1;
            PH_LATCH:                done_o = 1'b1;
            default:                 sw_zi_o = 1'b1;
        endcase
    end

    scs_phase_timer #(.W(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (nxt != state),
        .value   (tmr)
    );

    assign cnt_clr  = (state == PH_ZI) && (nxt == PH_INT);
    assign cnt_step = is_de && cmp_i;
    assign cnt_up   = (state != PH_DE2);
    assign dec      = (state == PH_DE1) ? DECW'(2) :
                      (state == PH_DE2) ? DECW'(1) : DECW'(0);

    scs_bcd_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (cnt_step),
        .up    (cnt_up),
        .dec   (dec),
        .value (cnt)
    );

    scs_correct u_corr (
        .sig_mag (sig_cnt),
        .sig_neg (sig_neg),
        .off_mag (cnt),
        .off_neg (pol),
        .out_mag (corr_mag),
        .out_neg (corr_neg)
    );

    // pass data and published result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rng       <= 1'b0;
            pol       <= 1'b0;
            ovl_acc   <= 1'b0;
            sig_cnt   <= '0;
            sig_neg   <= 1'b0;
            res_mag_o <= '0;
            res_neg_o <= 1'b0;
            res_ovr_o <= 1'b0;
        end else begin
            if (cnt_clr) rng <= range_hi_i;
            if (state == PH_INT && nxt == PH_DE1) pol <= in_neg_i;
            if (state == PH_LATCH && nxt == PH_ZI) ovl_acc <= 1'b0;
            else if (de_tmo)                       ovl_acc <= 1'b1;
            if (state == PH_ZI && pass) begin
                sig_cnt <= cnt;
                sig_neg <= pol;
            end
            if (state == PH_LATCH) begin
                res_mag_o <= corr_mag[19:0];
                res_neg_o <= corr_neg;
                res_ovr_o <= ovl_acc || (corr_mag[23:20] != 4'd0) || (corr_mag[19:16] > 4'd1);
            end
        end
    end
endmodule

// File: rtl/scs_conv_seq_chk.sv
module scs_conv_seq_chk #(
    parameter int DE_MAX = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmp_i,
    input logic        sw_zi_o,
    input logic        sw_int1_o,
    input logic        sw_int2_o,
    input logic        sw_de_pos_o,
    input logic        sw_de_neg_o,
    input logic        sw_rest_o,
    input logic        sw_x10_o,
    input logic        done_o,
    input logic [19:0] res_mag_o,
    input logic        res_neg_o,
    input logic        res_ovr_o
);
    logic        in_de;
    logic [31:0] de_run;

    assign in_de = sw_de_pos_o || sw_de_neg_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     de_run <= '0;
        else if (in_de) de_run <= de_run + 1;
        else            de_run <= '0;
    end

    a_r12_one_control: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sw_zi_o, sw_int1_o, sw_int2_o, sw_de_pos_o, sw_de_neg_o,
                    sw_rest_o, sw_x10_o, done_o}) == 1);

    a_r5_de_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_de && !cmp_i) |=> !in_de);

    a_r9_de_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        in_de |-> (de_run < DE_MAX));

    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> $stable({res_mag_o, res_neg_o, res_ovr_o}));

    a_r2_rest_then_x10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_rest_o) |-> sw_x10_o);

    a_r3_int_then_de: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_int1_o) || $fell(sw_int2_o)) |-> in_de);

    a_r10_ovr_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !res_ovr_o |-> (res_mag_o[19:16] < 4'd2));

    a_r8_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (res_mag_o == 20'd0) |-> !res_neg_o);
endmodule

bind scs_conv_seq scs_conv_seq_chk #(.DE_MAX(DE_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_i       (cmp_i),
    .sw_zi_o     (sw_zi_o),
    .sw_int1_o   (sw_int1_o),
    .sw_int2_o   (sw_int2_o),
    .sw_de_pos_o (sw_de_pos_o),
    .sw_de_neg_o (sw_de_neg_o),
    .sw_rest_o   (sw_rest_o),
    .sw_x10_o    (sw_x10_o),
    .done_o      (done_o),
    .res_mag_o   (res_mag_o),
    .res_neg_o   (res_neg_o),
    .res_ovr_o   (res_ovr_o)
);

// File: tb/scs_conv_seq_tb_top.sv
module scs_conv_seq_tb_top;
    localparam int IL = 40, IH = 8, ZL = 4, RL = 3, XL = 2, LL = 5, DM = 250;
    localparam int NC = 7;
    localparam int LIMIT = 150000;
    localparam int P_ZI = 0, P_INT = 1, P_DE1 = 2, P_R1 = 3, P_X1 = 4,
                   P_DE2 = 5, P_R2 = 6, P_X2 = 7, P_DE3 = 8, P_LAT = 9;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cmp_i, range_hi_i, in_neg_i;
    logic sw_zi_o, sw_int1_o, sw_int2_o, sw_de_pos_o, sw_de_neg_o, sw_rest_o, sw_x10_o, done_o;
    logic [19:0] res_mag_o;
    logic res_neg_o, res_ovr_o;

    scs_conv_seq #(
        .INT_LO_CLK(IL), .INT_HI_CLK(IH), .ZI_CLK(ZL), .REST_CLK(RL),
        .X10_CLK(XL), .LATCH_CLK(LL), .DE_MAX(DM)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .range_hi_i(range_hi_i), .in_neg_i(in_neg_i),
        .sw_zi_o(sw_zi_o), .sw_int1_o(sw_int1_o), .sw_int2_o(sw_int2_o),
        .sw_de_pos_o(sw_de_pos_o), .sw_de_neg_o(sw_de_neg_o), .sw_rest_o(sw_rest_o),
        .sw_x10_o(sw_x10_o), .done_o(done_o), .res_mag_o(res_mag_o),
        .res_neg_o(res_neg_o), .res_ovr_o(res_ovr_o)
    );

    // conversion plan: comparator-high clocks per DE phase, polarity, range
    int n_cfg [NC][2][3];
    bit neg_cfg [NC][2];
    bit rng_cfg [NC];

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    int m_ph, m_k, m_pass, cv, nx;
    bit m_pol;
    int e_mag;
    bit e_neg, e_ovr;

    task automatic set_cfg(input int i, input bit r,
                           input int a1, input int a2, input int a3, input bit an,
                           input int b1, input int b2, input int b3, input bit bn);
        rng_cfg[i] = r;
        n_cfg[i][0][0] = a1; n_cfg[i][0][1] = a2; n_cfg[i][0][2] = a3; neg_cfg[i][0] = an;
        n_cfg[i][1][0] = b1; n_cfg[i][1][1] = b2; n_cfg[i][1][2] = b3; neg_cfg[i][1] = bn;
    endtask

    function automatic int cvi();
        return (cv < NC) ? cv : NC - 1;
    endfunction

    function automatic bit model_cmp();
        int di;
        di = (m_ph == P_DE1) ? 0 : (m_ph == P_DE2) ? 1 : 2;
        if (m_ph != P_DE1 && m_ph != P_DE2 && m_ph != P_DE3) return 1'b0;
        return m_k < n_cfg[cvi()][m_pass][di];
    endfunction

    function automatic int eff(input int n);
        return (n < DM) ? n : DM;
    endfunction

    function automatic int reading(input int c, input int p);
        return 100 * eff(n_cfg[c][p][0]) - 10 * eff(n_cfg[c][p][1]) + eff(n_cfg[c][p][2]);
    endfunction

    function automatic int signed_val(input int c);
        int s, o;
        s = neg_cfg[c][0] ? -reading(c, 0) : reading(c, 0);
        o = neg_cfg[c][1] ? -reading(c, 1) : reading(c, 1);
        return s - o;
    endfunction

    function automatic bit timed_out(input int c);
        bit t = 1'b0;
        for (int p = 0; p < 2; p++)
            for (int d = 0; d < 3; d++)
                if (n_cfg[c][p][d] >= DM) t = 1'b1;
        return t;
    endfunction

    function automatic int dec_bcd(input logic [19:0] v);
        int r = 0;
        for (int i = 4; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (conversion %0d, phase %0d)", req, act, exp, cv, m_ph);
        end
    endtask

    // behavioural reference model, advanced on the same edges as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph <= P_ZI; m_k <= 0; m_pass <= 0; m_pol <= 1'b0; cv <= 0;
            e_mag <= 0; e_neg <= 1'b0; e_ovr <= 1'b0;
        end else begin
            nx = m_ph;
            case (m_ph)
                P_ZI:  if (m_k == ZL - 1) nx = P_INT;
                P_INT: if (m_k == (rng_cfg[cvi()] ? IH : IL) - 1) begin
                           nx = P_DE1;
                           m_pol <= neg_cfg[cvi()][m_pass];
                       end
                P_DE1: if (!model_cmp() || m_k == DM - 1) nx = P_R1;
                P_R1:  if (m_k == RL - 1) nx = P_X1;
                P_X1:  if (m_k == XL - 1) nx = P_DE2;
                P_DE2: if (!model_cmp() || m_k == DM - 1) nx = P_R2;
                P_R2:  if (m_k == RL - 1) nx = P_X2;
                P_X2:  if (m_k == XL - 1) nx = P_DE3;
                P_DE3: if (!model_cmp() || m_k == DM - 1) begin
                           nx = (m_pass == 1) ? P_LAT : P_ZI;
                           if (m_pass == 0) m_pass <= 1;
                       end
                P_LAT: begin
                           e_mag <= (signed_val(cvi()) < 0) ? -signed_val(cvi()) : signed_val(cvi());
                           e_neg <= signed_val(cvi()) < 0;
                           e_ovr <= timed_out(cvi()) ||
                                    ((signed_val(cvi()) < 0 ? -signed_val(cvi()) : signed_val(cvi())) > 19999);
                           if (m_k == LL - 1) begin
                               nx = P_ZI;
                               m_pass <= 0;
                               cv <= cv + 1;
                           end
                       end
                default: nx = P_ZI;
            endcase
            m_k  <= (nx != m_ph) ? 0 : m_k + 1;
            m_ph <= nx;
        end
    end

    initial begin
        int cyc;
        bit m_de;
        set_cfg(0, 1'b0,   5, 3, 2, 1'b0,   0, 0, 3, 1'b0);  // 472 - 3 = 469
        set_cfg(1, 1'b0,  20, 5, 7, 1'b1,   1, 9, 4, 1'b0);  // -1957 - 14 = -1971
        set_cfg(2, 1'b1,   3, 4, 6, 1'b0,   0, 0, 2, 1'b1);  // 266 + 2 = 268
        set_cfg(3, 1'b1,   0, 0, 5, 1'b0,   1, 9, 2, 1'b0);  // 5 - 12 = -7
        set_cfg(4, 1'b0, 210, 0, 0, 1'b0,   0, 0, 1, 1'b0);  // 20999, over range
        set_cfg(5, 1'b1, 300, 2, 1, 1'b0,   0, 0, 0, 1'b0);  // timeout: 24981
        set_cfg(6, 1'b0,   1, 2, 3, 1'b1,   1, 2, 3, 1'b1);  // exact cancel
        rst_n = 1'b0; cmp_i = 1'b0; range_hi_i = 1'b0; in_neg_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(sw_zi_o == 1'b1, "R1 zero-integrate after reset", int'(sw_zi_o), 1);
        chk(done_o == 1'b0, "R1 done low after reset", int'(done_o), 0);
        chk(res_mag_o == 20'd0 && !res_neg_o && !res_ovr_o, "R1 result cleared",
            int'(res_mag_o), 0);
        cyc = 0;
        while (cv < NC && cyc < LIMIT) begin
            // drive inputs for the coming edge from the model state
            cmp_i      = model_cmp();
            range_hi_i = rng_cfg[cvi()];
            in_neg_i   = neg_cfg[cvi()][m_pass];
            m_de       = (m_ph == P_DE1 || m_ph == P_DE2 || m_ph == P_DE3);
            chk(sw_zi_o == (m_ph == P_ZI), "R4 zero-integrate timing", int'(sw_zi_o), int'(m_ph == P_ZI));
            chk(sw_int1_o == (m_ph == P_INT && m_pass == 0), "R3 signal integrate timing",
                int'(sw_int1_o), int'(m_ph == P_INT && m_pass == 0));
            chk(sw_int2_o == (m_ph == P_INT && m_pass == 1), "R3 offset integrate timing",
                int'(sw_int2_o), int'(m_ph == P_INT && m_pass == 1));
            chk(sw_de_pos_o == (m_de && !m_pol), "R5/R6 positive de-integrate",
                int'(sw_de_pos_o), int'(m_de && !m_pol));
            chk(sw_de_neg_o == (m_de && m_pol), "R5/R6 negative de-integrate",
                int'(sw_de_neg_o), int'(m_de && m_pol));
            chk(sw_rest_o == (m_ph == P_R1 || m_ph == P_R2), "R2 rest phase",
                int'(sw_rest_o), int'(m_ph == P_R1 || m_ph == P_R2));
            chk(sw_x10_o == (m_ph == P_X1 || m_ph == P_X2), "R2 x10 phase",
                int'(sw_x10_o), int'(m_ph == P_X1 || m_ph == P_X2));
            chk(done_o == (m_ph == P_LAT), "R11 latch window", int'(done_o), int'(m_ph == P_LAT));
            chk($countones({sw_zi_o, sw_int1_o, sw_int2_o, sw_de_pos_o, sw_de_neg_o,
                            sw_rest_o, sw_x10_o, done_o}) == 1, "R12 single control",
                $countones({sw_zi_o, sw_int1_o, sw_int2_o, sw_de_pos_o, sw_de_neg_o,
                            sw_rest_o, sw_x10_o, done_o}), 1);
            chk(dec_bcd(res_mag_o) == e_mag && res_neg_o == e_neg && res_ovr_o == e_ovr,
                "R11 result update and hold", dec_bcd(res_mag_o), e_mag);
            // per-conversion result checks, second latch clock
            if (m_ph == P_LAT && m_k == 1) begin
                if (reading(cv, 1) == 0)
                    chk(dec_bcd(res_mag_o) == reading(cv, 0), "R7 pass reading",
                        dec_bcd(res_mag_o), reading(cv, 0));
                else
                    chk(dec_bcd(res_mag_o) == e_mag, "R8 corrected magnitude", dec_bcd(res_mag_o), e_mag);
                chk(res_neg_o == (signed_val(cv) < 0), "R8 corrected sign",
                    int'(res_neg_o), int'(signed_val(cv) < 0));
                if (timed_out(cv))
                    chk(res_ovr_o == 1'b1, "R9 timeout overload", int'(res_ovr_o), 1);
                else
                    chk(res_ovr_o == (e_mag > 19999), "R10 over-range flag",
                        int'(res_ovr_o), int'(e_mag > 19999));
            end
            @(negedge clk);
            cyc++;
        end
        if (cyc >= LIMIT) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d conversions", cv, NC);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule